// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block keeps a small bank of hardware tokens that two independent ports, called left and right, use to agree on who may touch a shared resource. A port takes a token by writing a 0 to it and gives it back by writing a 1. When it reads the token, the port learns whether it holds it. Each token is stored apart from any data memory, and it records which side holds it, if either does. It also records whether the side that does not hold it has a request waiting.

A request made while the other side holds the token is not lost. It is kept, and the waiting side takes the token in the same cycle that the holder releases it. If both sides request a free token in the same cycle, the left side wins and the right side's request is queued behind it. Each port captures its read result in its own output register. A later write from either side therefore cannot disturb a value that has already been read.

Top module: `sem_bank`

## Requirements
- R1: The index input of a port selects one of NUM_SEM (default 8) tokens. An access to one token leaves every other token unchanged.
- R2: A semaphore write looks only at bit 0 of the write data. 0 requests the token and 1 releases it or withdraws a waiting request. Bits 1 and up are ignored.
- R3: A read returns all zeros to the side that holds the selected token and all ones otherwise, the same value on every data bit. The result appears on the port's read data output in the cycle after the read is issued.
- R4: When a token is free, a 0 written by one side makes that side the holder, and the other side then reads ones.
- R5: A 0 written by the side that does not hold a token is queued. That side becomes the holder in the cycle after the holder writes 1.
- R6: When the holder writes 1 and no request is waiting, the token becomes free and both sides read ones.
- R7: When both sides write 0 to the same free token in the same cycle, the left side becomes the holder and the right side's request is queued.
- R8: A 1 written by a side that is waiting withdraws its request. A later release by the holder then leaves the token free.
- R9: The read data output keeps the last captured value until that port issues its next read, whatever either side writes in the meantime.
- R10: Synchronous reset frees every token, clears every waiting request and sets both read outputs to all ones.
- R11: An access is taken only when the port's select is high and its memory enable is low. With both high, the access is ignored: no token changes and the read output keeps its value.
- R12: A 0 written by the current holder leaves the holder and any waiting request unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; blocks semaphore access when high |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_idx | input | IDX_W | Left token index |
| l_wdata | input | DATA_W | Left write data; only bit 0 used |
| l_rdata | output | DATA_W | Left registered read result |
| r_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; blocks semaphore access when high |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_idx | input | IDX_W | Right token index |
| r_wdata | input | DATA_W | Right write data; only bit 0 used |
| r_rdata | output | DATA_W | Right registered read result |

## Verification
The bench targets the hand-over paths.

- **Queued request at release:** a design that drops the queued request would leave the token free at release instead of passing it to the waiting side.
- **Same-cycle request race:** a design that resolves the race wrongly would grant both sides, favour the right side, or forget the losing request.
- **Withdrawal before release:** a design that misses the withdrawal would hand the token to a side that no longer wants it.
- **Writes by the other side between reads:** these must leave the read register unchanged. A read path that is not registered would let the result follow the other side's writes.
- **Illegal select and enable pair, and high data bits:** the bench also writes with the select and memory enable both high, and writes with the upper data bits set. A flawed decoder would then grab a token or treat the upper bits as a command.

A long seeded run of mixed traffic from both ports is compared cycle by cycle against a model kept in the bench.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_state_t;

  // Updated waiting flag of one side, given its own write this cycle
  function automatic logic next_wait(input logic wants, input logic drops,
                                     input logic waiting);
    if (wants)      return 1'b1;
    else if (drops) return 1'b0;
    else            return waiting;
  endfunction

  // Read bit seen by a side: 0 only when it holds the token
  function automatic logic read_bit(input logic holds);
    return ~holds;
  endfunction
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic               mem_en,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SEM-1:0] req_vec,
  output logic [NUM_SEM-1:0] rel_vec,
  output logic               rd_en
);
  logic valid;
  logic [NUM_SEM-1:0] hit;

  assign valid = sel & ~mem_en;
  assign rd_en = valid & ~we;

  always_comb begin
    hit = '0;
    hit[idx] = 1'b1;
  end

  assign req_vec = (valid & we & ~wdata[0]) ? hit : '0;
  assign rel_vec = (valid & we &  wdata[0]) ? hit : '0;

  always_comb begin
    if (sel) p_onehot_r1: assert ($onehot0(req_vec | rel_vec));
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic owns_l,
  output logic owns_r
);
  tok_state_t st, st_nx;
  logic wait_l, wait_r, wait_l_nx, wait_r_nx;
  logic wl_eff, wr_eff;

  assign wl_eff = next_wait(l_req, l_rel, wait_l);
  assign wr_eff = next_wait(r_req, r_rel, wait_r);

  always_comb begin
    st_nx     = st;
    wait_l_nx = 1'b0;
    wait_r_nx = 1'b0;
    unique case (st)
      TOK_FREE: begin
        if (l_req) begin
          st_nx     = TOK_LEFT;
          wait_r_nx = r_req;
        end else if (r_req) begin
          st_nx = TOK_RIGHT;
        end
      end
      TOK_LEFT: begin
        if (l_rel) st_nx = wr_eff ? TOK_RIGHT : TOK_FREE;
        else       wait_r_nx = wr_eff;
      end
      TOK_RIGHT: begin
        if (r_rel) st_nx = wl_eff ? TOK_LEFT : TOK_FREE;
        else       wait_l_nx = wl_eff;
      end
      default: st_nx = TOK_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TOK_FREE;
      wait_l <= 1'b0;
      wait_r <= 1'b0;
    end else begin
      st     <= st_nx;
      wait_l <= wait_l_nx;
      wait_r <= wait_r_nx;
    end
  end

  assign owns_l = (st == TOK_LEFT);
  assign owns_r = (st == TOK_RIGHT);

  p_no_self_wait_r5: assert property (@(posedge clk) disable iff (rst)
    !(owns_l && wait_l) && !(owns_r && wait_r));
  p_free_no_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (st == TOK_FREE) |-> !(wait_l || wait_r));
  p_race_left_r7: assert property (@(posedge clk) disable iff (rst)
    (st == TOK_FREE && l_req && r_req) |=> (owns_l && wait_r));
  p_handoff_r5: assert property (@(posedge clk) disable iff (rst)
    (owns_l && l_rel && (r_req || (wait_r && !r_rel))) |=> owns_r);
  p_release_free_r6: assert property (@(posedge clk) disable iff (rst)
    (owns_r && r_rel && !l_req && (!wait_l || l_rel)) |=> (st == TOK_FREE));
  p_holder_repeat_r12: assert property (@(posedge clk) disable iff (rst)
    (owns_l && l_req && !l_rel && !r_req && !r_rel) |=> (owns_l && $stable(wait_r)));
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               blocked,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] holds,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{read_bit(holds[idx])}};
  end

  always_comb begin
    p_uniform_r3: assert (rdata == '0 || rdata == '1);
  end
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_illegal_r11: assert property (@(posedge clk) disable iff (rst)
    blocked |=> $stable(rdata));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_we,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_we,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel, l_holds, r_holds;
  logic l_rd, r_rd;

  sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_l (
    .sel(l_sel), .mem_en(l_mem_en), .we(l_we), .idx(l_idx), .wdata(l_wdata),
    .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd));
  sem_port_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_r (
    .sel(r_sel), .mem_en(r_mem_en), .we(r_we), .idx(r_idx), .wdata(r_wdata),
    .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_tok
    sem_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .owns_l(l_holds[i]), .owns_r(r_holds[i]));
  end

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .blocked(l_sel & l_mem_en),
    .idx(l_idx), .holds(l_holds), .rdata(l_rdata));
  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .blocked(r_sel & r_mem_en),
    .idx(r_idx), .holds(r_holds), .rdata(r_rdata));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    (l_holds & r_holds) == '0);
endmodule

// File: tb/sim_sem_bank.sv
`timescale 1ns/100ps
module sim_sem_bank;
  localparam int N  = 8;
  localparam int DW = 9;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_mem_en = 0, l_we = 0, r_sel = 0, r_mem_en = 0, r_we = 0;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  always #2.5 clk = ~clk;

  sem_bank #(.NUM_SEM(N), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_we(l_we), .l_idx(l_idx),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_we(r_we), .r_idx(r_idx),
    .r_wdata(r_wdata), .r_rdata(r_rdata));

  int total = 0, bad = 0;
  bit finished = 0;

  // Bench model: holder 0 none, 1 left, 2 right; queue flags per side
  int holder [N];
  bit q_l [N], q_r [N];
  logic [DW-1:0] exp_l = '1, exp_r = '1;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      holder[i] = 0; q_l[i] = 0; q_r[i] = 0;
    end
    exp_l = '1; exp_r = '1;
  endtask

  // One clock of activity on both ports; model follows the requirements
  task automatic cyc(bit ls, bit lm, bit lw, int li, logic [DW-1:0] ld,
                     bit rs, bit rm, bit rw, int ri, logic [DW-1:0] rd);
    bit lok, rok;
    int h;
    bit lq, lr, rq, rr, wl, wr;
    lok = ls && !lm; rok = rs && !rm;
    // reads capture the state before this edge
    if (lok && !lw) exp_l = (holder[li] == 1) ? '0 : '1;
    if (rok && !rw) exp_r = (holder[ri] == 2) ? '0 : '1;
    for (int i = 0; i < N; i++) begin
      lq = lok && lw && li == i && ld[0] == 1'b0;
      lr = lok && lw && li == i && ld[0] == 1'b1;
      rq = rok && rw && ri == i && rd[0] == 1'b0;
      rr = rok && rw && ri == i && rd[0] == 1'b1;
      h = holder[i];
      wl = lq ? 1 : (lr ? 0 : q_l[i]);
      wr = rq ? 1 : (rr ? 0 : q_r[i]);
      if (h == 0) begin
        if (lq) begin holder[i] = 1; q_r[i] = rq; end
        else if (rq) holder[i] = 2;
      end else if (h == 1) begin
        q_l[i] = 0;
        if (lr) begin holder[i] = wr ? 2 : 0; q_r[i] = 0; end
        else q_r[i] = wr;
      end else begin
        q_r[i] = 0;
        if (rr) begin holder[i] = wl ? 1 : 0; q_l[i] = 0; end
        else q_l[i] = wl;
      end
    end
    l_sel = ls; l_mem_en = lm; l_we = lw; l_idx = IW'(li); l_wdata = ld;
    r_sel = rs; r_mem_en = rm; r_we = rw; r_idx = IW'(ri); r_wdata = rd;
    @(posedge clk); #1;
    l_sel = 0; r_sel = 0; l_we = 0; r_we = 0; l_mem_en = 0; r_mem_en = 0;
  endtask

  task automatic lw(int i, logic [DW-1:0] d); cyc(1,0,1,i,d, 0,0,0,0,'0); endtask
  task automatic rw(int i, logic [DW-1:0] d); cyc(0,0,0,0,'0, 1,0,1,i,d); endtask
  task automatic rd_both(int li, int ri);     cyc(1,0,0,li,'0, 1,0,0,ri,'0); endtask

  task automatic read_check(string req, int i, logic [DW-1:0] el, logic [DW-1:0] er);
    rd_both(i, i);
    chk({req, " left"}, l_rdata, el);
    chk({req, " right"}, r_rdata, er);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10: reset state
    chk("R10 reset left", l_rdata, '1);
    chk("R10 reset right", r_rdata, '1);
    for (int i = 0; i < N; i++) read_check("R10 all free", i, '1, '1);

    // R4 + R1: each token taken by the left alone, others untouched
    for (int i = 0; i < N; i++) begin
      lw(i, 9'h000);
      for (int j = 0; j < N; j++)
        read_check("R1 R4 sweep", j, (j <= i) ? '0 : '1, '1);
    end
    // R6: release all with nothing waiting
    for (int i = 0; i < N; i++) lw(i, 9'h001);
    for (int i = 0; i < N; i++) read_check("R6 freed", i, '1, '1);

    // R2: upper bits set but bit0 = 0 still requests
    rw(3, 9'h1FE);
    read_check("R2 bit0 request", 3, '1, '0);
    // R12: holder repeats request; R5: left queues
    rw(3, 9'h000);
    read_check("R12 repeat", 3, '1, '0);
    lw(3, 9'h000);
    read_check("R5 queued", 3, '1, '0);
    rw(3, 9'h1FF);
    read_check("R5 handoff", 3, '0, '1);
    // R8: right queues then withdraws; left release frees
    rw(3, 9'h000);
    rw(3, 9'h001);
    lw(3, 9'h001);
    read_check("R8 withdraw", 3, '1, '1);

    // R7: race on free token
    cyc(1,0,1,5,9'h000, 1,0,1,5,9'h000);
    read_check("R7 left wins", 5, '0, '1);
    lw(5, 9'h001);
    read_check("R7 right queued", 5, '1, '0);
    rw(5, 9'h001);
    read_check("R6 free again", 5, '1, '1);

    // R11: select with memory enable high is ignored
    cyc(1,1,1,2,9'h000, 1,1,1,2,9'h000);
    read_check("R11 write ignored", 2, '1, '1);
    lw(2, 9'h000);
    rd_both(2, 2);
    cyc(1,1,0,0,'0, 0,0,0,0,'0);
    chk("R11 read ignored", l_rdata, '0);

    // R9: captured value stable through other side writes
    rd_both(2, 2);
    rw(2, 9'h000);
    lw(2, 9'h001);
    chk("R9 left hold", l_rdata, '0);
    chk("R9 right hold", r_rdata, '1);
    read_check("R3 after handoff", 2, '1, '0);
    rw(2, 9'h001);

    // Mixed traffic vs model (R3, R9 checked every cycle)
    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0,1), ($urandom_range(0,7) == 0), $urandom_range(0,1),
          $urandom_range(0,N-1), DW'($urandom),
          $urandom_range(0,1), ($urandom_range(0,7) == 0), $urandom_range(0,1),
          $urandom_range(0,N-1), DW'($urandom));
      chk("R3 R9 mixed left", l_rdata, exp_l);
      chk("R3 R9 mixed right", r_rdata, exp_r);
    end

    // R10: reset mid-use
    lw(1, 9'h000); rw(1, 9'h000);
    rst = 1; @(posedge clk); #1 rst = 0;
    model_reset();
    chk("R10 rdata after reset", l_rdata, '1);
    read_check("R10 token freed", 1, '1, '1);
    lw(1, 9'h001);
    read_check("R10 wait cleared", 1, '1, '1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule